// File: doc/BRIEF.md
# Infrared FIFO Transfer Sequencer

This block moves 32-bit words between an infrared link's transmit and receive FIFOs and the serial transceiver path. A 16-bit control word from the host sets it up. The word carries an enable, a line mode, a direction and a slow-mode baud divisor. Once the word is valid, the block spends one warm-up cycle switching on the CRC unit, the codec and the gated clocks. Only after that does it start moving FIFO traffic.

In transmit, the block pulls words from the TX FIFO with an active-low read enable. It stays at most one word ahead of the serialiser and loads each word into it on the following cycle. In receive, the block writes each finished deserialised word into the RX FIFO with an active-low write enable. When the RX FIFO fills, it raises a request so the host side empties that FIFO into memory. A small status word gives the two FIFO empty flags and a latched CRC result. Reading the status word clears the CRC result.

Top module: `irda_xfer_ctrl`

## Requirements
- R1: Control word layout: bit 0 is enable, bits 3:1 are the mode (0 UART, 1 SIR, 2 MIR, 3 FIR, 4 VFIR), bit 4 is direction (1 = transmit, 0 = receive), and bits 15:5 are the baud divisor. While the word is valid, mode_o shows the mode. div_o always shows bits 15:5.
- R2: A mode code of 5, 6 or 7 counts as disabled. All unit and clock enables stay low and neither FIFO enable is asserted.
- R3: One clock edge after a valid enabled word is applied, crc_en_o, codec_en_o and codec_clk_en_o go high. No FIFO read or write is issued before the second edge.
- R4: After warm-up, fifo_rclk_en_o is high only in transmit and fifo_wclk_en_o is high only in receive.
- R5: In transmit, tx_rd_no is low exactly when all of these hold: the block is running, the TX FIFO is not empty, ser_ready_i is high, and no word fetched in the previous cycle is still being delivered. As a result, two reads never occur on consecutive cycles.
- R6: ser_load_o is high in the cycle after each TX read, and ser_data_o then equals tx_data_i.
- R7: tx_done_o is high when the block is running in transmit, the TX FIFO is empty, and no fetch is in flight.
- R8: In receive, rx_wr_no is low in the cycle where rx_word_valid_i is high and the RX FIFO is not full. rx_data_o equals rx_word_i.
- R9: upload_req_o goes high on the edge after RX full is seen while running in receive. It stays high until the RX empty flag is seen or the enable is dropped. A full flag takes priority over an empty flag.
- R10: status_o bit 0 is the TX empty flag, bit 1 is the RX empty flag, and bit 2 is the CRC error flag (1 = last frame failed).
- R11: The CRC error flag takes the inverse of crc_ok_i at each frame end in receive. It is cleared by a status read. A frame end in the same cycle as a status read wins.
- R12: Clearing the enable deasserts both FIFO enables and all unit enables in the same cycle. The block returns to idle, and re-enabling repeats the warm-up cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 16 | Host control word |
| stat_rd_i | input | 1 | Host reads the status word |
| status_o | output | 3 | {crc error, RX empty, TX empty} |
| mode_o | output | 3 | Active line mode to the codec |
| div_o | output | 11 | Baud divisor for slow modes |
| crc_en_o | output | 1 | CRC unit enable |
| codec_en_o | output | 1 | Codec enable |
| codec_clk_en_o | output | 1 | Codec clock enable |
| fifo_rclk_en_o | output | 1 | TX FIFO read clock enable |
| fifo_wclk_en_o | output | 1 | RX FIFO write clock enable |
| tx_empty_i | input | 1 | TX FIFO empty flag |
| tx_rd_no | output | 1 | TX FIFO read enable, active low |
| tx_data_i | input | 32 | TX FIFO read data, valid the cycle after a read |
| ser_ready_i | input | 1 | Serialiser can take a word; held until load |
| ser_load_o | output | 1 | Load strobe to the serialiser |
| ser_data_o | output | 32 | Word to the serialiser |
| tx_done_o | output | 1 | Transmit drained |
| rx_word_valid_i | input | 1 | Deserialised word complete |
| rx_word_i | input | 32 | Deserialised word |
| rx_full_i | input | 1 | RX FIFO full flag |
| rx_empty_i | input | 1 | RX FIFO empty flag |
| rx_wr_no | output | 1 | RX FIFO write enable, active low |
| rx_data_o | output | 32 | RX FIFO write data |
| upload_req_o | output | 1 | Request to move RX FIFO to host memory |
| frame_end_i | input | 1 | Received frame finished |
| crc_ok_i | input | 1 | CRC result for that frame |

## Verification
The transmit path is driven with random FIFO empty and serialiser ready patterns. This shows whether the one-word-ahead throttle holds when ready stays high and when data runs dry in the middle of a burst. The receive path gets random word strobes, with full and empty flags that sometimes arrive together and status reads that sometimes coincide with frame ends. These patterns separate the flag priorities of the upload request and the CRC latch. Directed steps cover each case on its own:
- the warm-up cycle;
- an illegal mode code;
- a disable in the middle of a transfer, followed by a restart;
- a disable with an upload request pending.

// File: rtl/irda_xfer_pkg.sv
package irda_xfer_pkg;
  localparam int CTRL_W   = 16;
  localparam int EN_BIT   = 0;
  localparam int MODE_LSB = 1;
  localparam int MODE_W   = 3;
  localparam int DIR_BIT  = 4;
  localparam int DIV_LSB  = 5;
  localparam int DIV_W    = CTRL_W - DIV_LSB;

  typedef enum logic [MODE_W-1:0] {
    MODE_UART  = 3'd0,
    MODE_SLOW  = 3'd1,
    MODE_MED   = 3'd2,
    MODE_FAST  = 3'd3,
    MODE_VFAST = 3'd4
  } line_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/irda_ctrl_seq.sv
module irda_ctrl_seq
  import irda_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              en_o,
  output logic              run_tx_o,
  output logic              run_rx_o,
  output logic              crc_en_o,
  output logic              codec_en_o,
  output logic              codec_clk_en_o,
  output logic              fifo_rclk_en_o,
  output logic              fifo_wclk_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DIV_W-1:0]  div_o
);
  logic [MODE_W-1:0] mode;
  logic              dir_tx, awake, run;
  seq_st_e           st_q, st_d;

  assign mode   = ctrl_i[MODE_LSB +: MODE_W];
  assign dir_tx = ctrl_i[DIR_BIT];
  // illegal mode codes count as disabled
  assign en_o   = ctrl_i[EN_BIT] && (mode <= MODE_VFAST);

  always_comb begin
    st_d = st_q;
    if (!en_o)                st_d = ST_IDLE;
    else if (st_q == ST_IDLE) st_d = ST_WARM;
    else                      st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  // qualified with en_o so a disable acts in the same cycle
  assign awake          = en_o && (st_q != ST_IDLE);
  assign run            = en_o && (st_q == ST_RUN);
  assign run_tx_o       = run && dir_tx;
  assign run_rx_o       = run && !dir_tx;
  assign crc_en_o       = awake;
  assign codec_en_o     = awake;
  assign codec_clk_en_o = awake;
  assign fifo_rclk_en_o = awake && dir_tx;
  assign fifo_wclk_en_o = awake && !dir_tx;
  assign mode_o         = en_o ? mode : '0;
  assign div_o          = ctrl_i[DIV_LSB +: DIV_W];

  // R12
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> st_q == ST_IDLE);
  // R3
  warm_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE |=> st_q != ST_RUN);
endmodule

// File: rtl/irda_tx_fetch.sv
module irda_tx_fetch #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tx_empty_i,
  input  logic              ser_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_rd_no,
  output logic              ser_load_o,
  output logic [DATA_W-1:0] ser_data_o,
  output logic              tx_done_o
);
  logic rd, fetch_q;

  // at most one word in flight toward the serialiser
  assign rd       = act_i && !tx_empty_i && ser_ready_i && !fetch_q;
  assign tx_rd_no = !rd;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fetch_q <= 1'b0;
    else         fetch_q <= rd;

  assign ser_load_o = fetch_q;
  assign ser_data_o = tx_data_i;
  assign tx_done_o  = act_i && tx_empty_i && !fetch_q;

  // R5
  one_ahead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rd_no |=> tx_rd_no);
  // R6
  load_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rd_no |=> ser_load_o);
  // R5
  rd_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_rd_no |-> !tx_empty_i && ser_ready_i);
endmodule

// File: rtl/irda_rx_store.sv
module irda_rx_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              act_i,
  input  logic              rx_word_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic              frame_end_i,
  input  logic              crc_ok_i,
  input  logic              stat_rd_i,
  output logic              rx_wr_no,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              upload_req_o,
  output logic              crc_bad_o
);
  logic up_q, crc_bad_q;

  assign rx_wr_no  = !(act_i && rx_word_valid_i && !rx_full_i);
  assign rx_data_o = rx_word_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  up_q <= 1'b0;
    else if (!en_i)               up_q <= 1'b0;
    else if (act_i && rx_full_i)  up_q <= 1'b1;
    else if (rx_empty_i)          up_q <= 1'b0;

  // frame end beats a status read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   crc_bad_q <= 1'b0;
    else if (act_i && frame_end_i) crc_bad_q <= !crc_ok_i;
    else if (stat_rd_i)            crc_bad_q <= 1'b0;

  assign upload_req_o = up_q;
  assign crc_bad_o    = crc_bad_q;

  // R9
  upload_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && rx_full_i |=> upload_req_o);
  // R11
  crc_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && frame_end_i |=> crc_bad_o == !$past(crc_ok_i));
  // R8
  wr_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_wr_no |-> !rx_full_i);
endmodule

// File: rtl/irda_xfer_ctrl.sv
module irda_xfer_ctrl
  import irda_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              stat_rd_i,
  output logic [2:0]        status_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              crc_en_o,
  output logic              codec_en_o,
  output logic              codec_clk_en_o,
  output logic              fifo_rclk_en_o,
  output logic              fifo_wclk_en_o,
  input  logic              tx_empty_i,
  output logic              tx_rd_no,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ser_ready_i,
  output logic              ser_load_o,
  output logic [DATA_W-1:0] ser_data_o,
  output logic              tx_done_o,
  input  logic              rx_word_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  output logic              rx_wr_no,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              upload_req_o,
  input  logic              frame_end_i,
  input  logic              crc_ok_i
);
  logic en, run_tx, run_rx, crc_bad;

  irda_ctrl_seq i_seq (
    .clk_i, .rst_ni, .ctrl_i,
    .en_o(en), .run_tx_o(run_tx), .run_rx_o(run_rx),
    .crc_en_o, .codec_en_o, .codec_clk_en_o,
    .fifo_rclk_en_o, .fifo_wclk_en_o, .mode_o, .div_o
  );

  irda_tx_fetch #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni, .act_i(run_tx), .tx_empty_i, .ser_ready_i, .tx_data_i,
    .tx_rd_no, .ser_load_o, .ser_data_o, .tx_done_o
  );

  irda_rx_store #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni, .en_i(en), .act_i(run_rx), .rx_word_valid_i, .rx_word_i,
    .rx_full_i, .rx_empty_i, .frame_end_i, .crc_ok_i, .stat_rd_i,
    .rx_wr_no, .rx_data_o, .upload_req_o, .crc_bad_o(crc_bad)
  );

  assign status_o = {crc_bad, rx_empty_i, tx_empty_i};

  // R12
  no_fifo_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_en_o |-> tx_rd_no && rx_wr_no);
endmodule

// File: tb/test_irda_xfer_ctrl.sv
`timescale 1ns/1ps
module test_irda_xfer_ctrl;
  logic clk = 0, rst_ni = 0;
  logic [15:0] ctrl = '0;
  logic stat_rd = 0, tx_empty = 1, ser_ready = 0, rx_valid = 0, rx_full = 0;
  logic rx_empty = 1, frame_end = 0, crc_ok = 1;
  logic [31:0] tx_data = '0, rx_word = '0;
  logic [2:0] status, mode;
  logic [10:0] div;
  logic crc_en, codec_en, codec_clk_en, rclk_en, wclk_en, tx_rd_n, ser_load, tx_done;
  logic rx_wr_n, upload;
  logic [31:0] ser_data, rx_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irda_xfer_ctrl i_irda_xfer_ctrl (
    .clk_i(clk), .rst_ni, .ctrl_i(ctrl), .stat_rd_i(stat_rd), .status_o(status),
    .mode_o(mode), .div_o(div), .crc_en_o(crc_en), .codec_en_o(codec_en),
    .codec_clk_en_o(codec_clk_en), .fifo_rclk_en_o(rclk_en), .fifo_wclk_en_o(wclk_en),
    .tx_empty_i(tx_empty), .tx_rd_no(tx_rd_n), .tx_data_i(tx_data),
    .ser_ready_i(ser_ready), .ser_load_o(ser_load), .ser_data_o(ser_data),
    .tx_done_o(tx_done), .rx_word_valid_i(rx_valid), .rx_word_i(rx_word),
    .rx_full_i(rx_full), .rx_empty_i(rx_empty), .rx_wr_no(rx_wr_n),
    .rx_data_o(rx_data), .upload_req_o(upload), .frame_end_i(frame_end),
    .crc_ok_i(crc_ok)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(bit en, int md, bit tx, int dv);
    return {dv[10:0], tx, md[2:0], en};
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(20ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic fetch_e, up_e, crc_e;
    void'($urandom(32'h1234));
    repeat (2) @(negedge clk);
    rst_ni = 1;
    #1;
    chk("R10 reset status", status, 3'b011);
    chk("R12 reset enables", {crc_en, rclk_en, wclk_en, tx_rd_n, rx_wr_n, upload}, 6'b000110);

    // transmit start
    ctrl = cw(1, 3, 1, 11'h5A3); tx_empty = 0; ser_ready = 1;
    #1;
    chk("R1 mode", mode, 3);
    chk("R1 div", div, 11'h5A3);
    chk("R3 not yet awake", crc_en, 0);
    chk("R3 no read at idle", tx_rd_n, 1);
    cyc(); #1;
    chk("R3 units on", {crc_en, codec_en, codec_clk_en}, 3'b111);
    chk("R4 tx clocks", {rclk_en, wclk_en}, 2'b10);
    chk("R3 no read in warm-up", tx_rd_n, 1);
    cyc(); #1;
    chk("R5 first read", tx_rd_n, 0);
    fetch_e = 1;
    cyc();

    // random transmit
    for (int i = 0; i < 300; i++) begin
      logic exp_rd;
      tx_empty = ($urandom % 4) == 0;
      ser_ready = ($urandom % 3) != 0;
      tx_data = $urandom;
      #1;
      exp_rd = !tx_empty && ser_ready && !fetch_e;
      chk("R5 tx read", tx_rd_n, !exp_rd);
      chk("R6 load", ser_load, fetch_e);
      if (fetch_e) chk("R6 data", ser_data, tx_data);
      chk("R7 done", tx_done, tx_empty && !fetch_e);
      chk("R10 tx empty bit", status[0], tx_empty);
      cyc();
      fetch_e = exp_rd;
    end

    // disable mid-transfer then restart
    tx_empty = 0; ser_ready = 0; cyc(); cyc();
    ser_ready = 1; #1;
    chk("R5 read when ready", tx_rd_n, 0);
    ctrl = cw(0, 3, 1, 0); #1;
    chk("R12 read drops same cycle", tx_rd_n, 1);
    chk("R12 units drop", {crc_en, rclk_en}, 2'b00);
    cyc(); ctrl = cw(1, 3, 1, 0); #1;
    chk("R12 idle after re-enable", tx_rd_n, 1);
    cyc(); #1;
    chk("R12 warm-up repeated", {crc_en, tx_rd_n}, 2'b11);
    cyc(); #1;
    chk("R12 running again", tx_rd_n, 0);
    ser_ready = 0; cyc(); cyc();

    // illegal mode
    ctrl = cw(1, 6, 1, 0); ser_ready = 1; cyc(); cyc(); #1;
    chk("R2 mode 6 off", {crc_en, codec_en, rclk_en, tx_rd_n}, 4'b0001);
    chk("R2 mode out", mode, 0);
    ctrl = cw(1, 7, 0, 0); rx_valid = 1; rx_empty = 0; #1;
    chk("R2 mode 7 no write", rx_wr_n, 1);
    rx_valid = 0; ser_ready = 0;

    // receive start
    ctrl = cw(1, 4, 0, 0); cyc(); #1;
    chk("R4 rx clocks", {rclk_en, wclk_en}, 2'b01);
    rx_valid = 1; #1;
    chk("R3 no write in warm-up", rx_wr_n, 1);
    cyc();
    up_e = 0; crc_e = status[2];
    for (int i = 0; i < 300; i++) begin
      rx_valid = $urandom % 2;
      rx_word = $urandom;
      rx_full = ($urandom % 6) == 0;
      rx_empty = ($urandom % 5) == 0;
      frame_end = ($urandom % 7) == 0;
      crc_ok = $urandom % 2;
      stat_rd = ($urandom % 5) == 0;
      #1;
      chk("R8 write", rx_wr_n, !(rx_valid && !rx_full));
      if (!rx_wr_n) chk("R8 data", rx_data, rx_word);
      chk("R9 upload", upload, up_e);
      chk("R10 status", status, {crc_e, rx_empty, tx_empty});
      cyc();
      if (rx_full) up_e = 1; else if (rx_empty) up_e = 0;
      if (frame_end) crc_e = !crc_ok; else if (stat_rd) crc_e = 0;
    end

    // directed corner cases
    rx_valid = 0; rx_full = 0; rx_empty = 0;
    frame_end = 1; crc_ok = 0; stat_rd = 1; cyc(); #1;
    chk("R11 frame end beats read", status[2], 1);
    frame_end = 0; stat_rd = 0; cyc(); #1;
    chk("R11 latched", status[2], 1);
    stat_rd = 1; cyc(); #1;
    chk("R11 read clears", status[2], 0);
    stat_rd = 0;
    rx_full = 1; rx_empty = 1; cyc(); #1;
    chk("R9 full wins", upload, 1);
    rx_full = 0; rx_empty = 0; cyc(); #1;
    chk("R9 held", upload, 1);
    ctrl = cw(0, 4, 0, 0); cyc(); #1;
    chk("R9 cleared by disable", upload, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule